// File: doc/BRIEF.md
# Peripheral Interrupt Forwarding Controller

This block sits between a set of on-chip peripheral interrupt sources and a parent interrupt controller. Every source line is conditioned on its own. A per-line polarity bit can invert it, and a per-line mask bit can block it. Each conditioned line then drives one dedicated output toward the parent. Output k carries source k. The parent adds its own fixed base number, and that number is not part of this block.

A build-time parameter picks one of two variants, and both use the same register map. The pass-through variant registers the conditioned level and forwards it. The latching variant records each rising edge of the conditioned line in a sticky status bit. The output then stays asserted until software writes a one to the matching clear bit.

Software reaches the control state through a small 16-bit register port. The port has a word address, a write strobe, write data and read data. Reads are combinational from the current address. Each register word covers 16 lines, and the number of lines is a parameter of at most 64.

Top module: `irqfwd_ctrl`

## Requirements
- R1: After reset every implemented mask bit reads 1 and every polarity and status bit reads 0. Mask bits for lines that do not exist read 0. With 40 lines, mask word 0 reads 0xFFFF and mask word 2 reads 0x00FF. All outputs are 0.
- R2: Word address bits [3:2] select the register group: 0 is mask, 1 is polarity, 2 is status/clear. Bits [1:0] select the bank, so the byte offset is four times the word address. Line n sits at bit n%16 of bank n/16. A mask or polarity write can be read back at once.
- R3: A mask bit of 1 keeps its line's output at 0. A mask bit of 0 lets the conditioned line through.
- R4: A polarity bit of 1 inverts its input before masking. A polarity bit of 0 passes the input unchanged.
- R5: In the pass-through variant (LATCHING=0), each output equals the conditioned, unmasked input of the previous cycle. A status read returns the current conditioned input levels.
- R6: In the latching variant (LATCHING=1), a 0-to-1 change of the conditioned line sets its status bit. The bit stays set after the input falls. The output is the status bit gated by the mask. A status read returns the status bits.
- R7: Writing 1 to a status/clear bit clears that line's status. Writing 0 leaves it unchanged.
- R8: When a set and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: Bits for lines at or above NUM_LINES read 0 and ignore writes. Word addresses 12 to 15 read 0 and ignore writes.
- R10: A change on an input line reaches the output only after the next rising clock edge, never before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_LINES | Peripheral interrupt inputs, synchronous to clk |
| bus_addr | input | 4 | Register word address (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_fwd | output | NUM_LINES | Per-line outputs toward the parent controller |

## Verification
Some properties are checked on every cycle. Outputs are quiet after reset. A latched status bit never drops without a clear. A status bit never rises without a detected edge, and a set always survives a clear in the same cycle. A pass-through output always equals the previous cycle's conditioned, unmasked input. Other points only show up in the bench's scenarios: the bit and bank placement of the register map, the readback of words that are partly or wholly unimplemented, the effect of zero-valued clear writes, and the absence of output change before the clock edge.

// File: rtl/irqfwd_pkg.sv
package irqfwd_pkg;

  localparam int REG_W     = 16;
  localparam int MAX_LINES = 64;
  localparam int WADDR_W   = 4;

  typedef enum logic [1:0] {
    GRP_MASK = 2'd0,
    GRP_POL  = 2'd1,
    GRP_STAT = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  function automatic grp_e addr_group(input logic [WADDR_W-1:0] a);
    return grp_e'(a[3:2]);
  endfunction

  function automatic logic [1:0] addr_bank(input logic [WADDR_W-1:0] a);
    return a[1:0];
  endfunction

  function automatic logic [REG_W-1:0] bank_word(input logic [MAX_LINES-1:0] v,
                                                 input logic [1:0] b);
    return v[b*REG_W +: REG_W];
  endfunction

endpackage

// File: rtl/irqfwd_regs.sv
module irqfwd_regs
  import irqfwd_pkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WADDR_W-1:0]   bus_addr,
  input  logic                 bus_we,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] pol_q,
  output logic [NUM_LINES-1:0] clr_pulse
);

  grp_e       grp;
  logic [1:0] bank;

  assign grp  = addr_group(bus_addr);
  assign bank = addr_bank(bus_addr);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int BANK = n / REG_W;
    localparam int BIT  = n % REG_W;
    logic hit;

    assign hit = bus_we && (bank == 2'(BANK));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[n] <= 1'b1;
        pol_q[n]  <= 1'b0;
      end else begin
        if (hit && grp == GRP_MASK) mask_q[n] <= bus_wdata[BIT];
        if (hit && grp == GRP_POL)  pol_q[n]  <= bus_wdata[BIT];
      end
    end

    assign clr_pulse[n] = hit && (grp == GRP_STAT) && bus_wdata[BIT];
  end

endmodule

// File: rtl/irqfwd_line_cond.sv
module irqfwd_line_cond #(
  parameter int NUM_LINES = 40,
  parameter bit LATCHING  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] irq_out,
  output logic [NUM_LINES-1:0] stat_view,
  output logic [NUM_LINES-1:0] cond,
  output logic [NUM_LINES-1:0] set_evt
);

  assign cond = src ^ pol;

  if (LATCHING) begin : g_latch
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] stat_q;

    assign set_evt = cond & ~prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= '0;
        stat_q <= '0;
      end else begin
        prev_q <= cond;
        stat_q <= (stat_q & ~clr) | set_evt;
      end
    end

    assign irq_out   = stat_q & ~mask;
    assign stat_view = stat_q;
  end else begin : g_pass
    logic [NUM_LINES-1:0] out_q;
    logic                 unused_clr;

    always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= cond & ~mask;
    end

    assign unused_clr = ^clr;
    assign set_evt    = '0;
    assign irq_out    = out_q;
    assign stat_view  = cond;
  end

endmodule

// File: rtl/irqfwd_rdmux.sv
module irqfwd_rdmux
  import irqfwd_pkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input  logic [WADDR_W-1:0]   bus_addr,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] stat_view,
  output logic [REG_W-1:0]     bus_rdata
);

  logic [MAX_LINES-1:0] mask64, pol64, stat64;

  always_comb begin
    mask64 = '0;
    pol64  = '0;
    stat64 = '0;
    mask64[NUM_LINES-1:0] = mask;
    pol64[NUM_LINES-1:0]  = pol;
    stat64[NUM_LINES-1:0] = stat_view;
    unique case (addr_group(bus_addr))
      GRP_MASK: bus_rdata = bank_word(mask64, addr_bank(bus_addr));
      GRP_POL:  bus_rdata = bank_word(pol64,  addr_bank(bus_addr));
      GRP_STAT: bus_rdata = bank_word(stat64, addr_bank(bus_addr));
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqfwd_ctrl.sv
module irqfwd_ctrl
  import irqfwd_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter bit LATCHING  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_src,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_we,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_fwd
);

  // Named internal events, also used by the bound checker.
  logic [NUM_LINES-1:0] mask_w, pol_w, clr_w, cond_w, set_w, stat_w;

  irqfwd_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .mask_q    (mask_w),
    .pol_q     (pol_w),
    .clr_pulse (clr_w)
  );

  irqfwd_line_cond #(.NUM_LINES(NUM_LINES), .LATCHING(LATCHING)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .src       (irq_src),
    .mask      (mask_w),
    .pol       (pol_w),
    .clr       (clr_w),
    .irq_out   (irq_fwd),
    .stat_view (stat_w),
    .cond      (cond_w),
    .set_evt   (set_w)
  );

  irqfwd_rdmux #(.NUM_LINES(NUM_LINES)) u_rdmux (
    .bus_addr  (bus_addr),
    .mask      (mask_w),
    .pol       (pol_w),
    .stat_view (stat_w),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: rtl/irqfwd_chk.sv
module irqfwd_chk #(
  parameter int NUM_LINES = 40,
  parameter bit LATCHING  = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_fwd,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] cond,
  input logic [NUM_LINES-1:0] set_evt,
  input logic [NUM_LINES-1:0] clr_evt,
  input logic [NUM_LINES-1:0] stat_view
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_fwd == '0));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCHING != 0) |-> ((($past(stat_view) & ~$past(clr_evt)) & ~stat_view) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCHING != 0) |-> (($past(set_evt) & ~stat_view) == '0));

  // R6
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCHING != 0) |-> ((~$past(stat_view) & stat_view & ~$past(set_evt)) == '0));

  // R5
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LATCHING == 0) |-> (irq_fwd == ($past(cond) & ~$past(mask_q))));

endmodule

bind irqfwd_ctrl irqfwd_chk #(.NUM_LINES(NUM_LINES), .LATCHING(LATCHING)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_fwd   (irq_fwd),
  .mask_q    (mask_w),
  .cond      (cond_w),
  .set_evt   (set_w),
  .clr_evt   (clr_w),
  .stat_view (stat_w)
);

// File: tb/irqfwd_ctrl_bench.sv
module irqfwd_ctrl_bench;

  localparam int NL = 40;
  localparam logic [63:0] IMPL = (NL >= 64) ? '1 : ((64'd1 << NL) - 64'd1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [NL-1:0] src;
  logic [3:0]    addr;
  logic          we;
  logic [15:0]   wdata;
  logic [15:0]   rd_l, rd_p;
  logic [NL-1:0] out_l, out_p;

  irqfwd_ctrl #(.NUM_LINES(NL), .LATCHING(1'b1)) u_irqfwd_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rd_l), .irq_fwd(out_l));

  irqfwd_ctrl #(.NUM_LINES(NL), .LATCHING(1'b0)) u_irqfwd_ctrl_pass (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rd_p), .irq_fwd(out_p));

  // Reference model state, 64 lines wide, unimplemented bits held at 0.
  logic [63:0] m_mask, m_pol, m_stat, m_prev, m_outp, m_src;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [63:0] word_place(input logic [1:0] b, input logic [15:0] d);
    return 64'(d) << (16 * int'(b));
  endfunction

  function automatic logic [15:0] word_pick(input logic [63:0] v, input logic [1:0] b);
    logic [63:0] t;
    t = v >> (16 * int'(b));
    return t[15:0];
  endfunction

  function automatic logic [15:0] exp_read(input logic [3:0] a, input bit latching);
    case (a[3:2])
      2'd0:    return word_pick(m_mask, a[1:0]);
      2'd1:    return word_pick(m_pol, a[1:0]);
      2'd2:    return latching ? word_pick(m_stat, a[1:0])
                               : word_pick((m_src ^ m_pol) & IMPL, a[1:0]);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk_out(input string tag, input logic [NL-1:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp[NL-1:0]) begin
      fails++;
      $display("FAIL %s: output got %h expected %h", tag, act, exp[NL-1:0]);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: read got %h expected %h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; drives, predicts the next rising edge, checks.
  task automatic step(input logic [63:0] s, input logic w, input logic [3:0] a,
                      input logic [15:0] d, input string tag);
    logic [63:0] cnd, clrv, msk;
    src = s[NL-1:0]; we = w; addr = a; wdata = d;
    m_src  = s & IMPL;
    cnd    = (m_src ^ m_pol) & IMPL;
    m_outp = cnd & ~m_mask;
    clrv   = (w && a[3:2] == 2'd2) ? (word_place(a[1:0], d) & IMPL) : 64'd0;
    m_stat = (m_stat & ~clrv) | (cnd & ~m_prev);
    m_prev = cnd;
    msk    = word_place(a[1:0], 16'hFFFF);
    if (w && a[3:2] == 2'd0) m_mask = ((m_mask & ~msk) | word_place(a[1:0], d)) & IMPL;
    if (w && a[3:2] == 2'd1) m_pol  = ((m_pol  & ~msk) | word_place(a[1:0], d)) & IMPL;
    @(negedge clk);
    we = 1'b0;
    chk_out({tag, " latch"}, out_l, m_stat & ~m_mask);
    chk_out({tag, " pass"},  out_p, m_outp);
    chk_rd ({tag, " latch"}, rd_l, exp_read(a, 1'b1));
    chk_rd ({tag, " pass"},  rd_p, exp_read(a, 1'b0));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0;
    m_mask = IMPL; m_pol = '0; m_stat = '0; m_prev = '0; m_outp = '0; m_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values, including the partly implemented mask word 2
    step(64'd0, 1'b0, 4'd0, 16'h0, "R1");
    chk_rd("R1 mask word0", rd_l, 16'hFFFF);
    step(64'd0, 1'b0, 4'd2, 16'h0, "R1");
    chk_rd("R1 mask word2", rd_l, 16'h00FF);
    step(64'd0, 1'b0, 4'd4, 16'h0, "R1");
    step(64'd0, 1'b0, 4'd8, 16'h0, "R1");

    // R2: bank placement and readback
    step(64'd0, 1'b1, 4'd1, 16'hA5A5, "R2");
    step(64'd0, 1'b1, 4'd6, 16'h003C, "R2");
    step(64'd0, 1'b1, 4'd6, 16'h0000, "R2");
    step(64'd0, 1'b1, 4'd0, 16'h0000, "R2");
    step(64'd0, 1'b1, 4'd1, 16'h0000, "R2");
    step(64'd0, 1'b1, 4'd2, 16'h0000, "R2");

    // R9: unimplemented bits and words
    step(64'd0, 1'b1, 4'd2, 16'hFFFF, "R9");
    chk_rd("R9 partial word", rd_l, 16'h00FF);
    step(64'd0, 1'b1, 4'd3, 16'hFFFF, "R9");
    step(64'd0, 1'b1, 4'd12, 16'hFFFF, "R9");
    step(64'd0, 1'b1, 4'd15, 16'hFFFF, "R9");
    step(64'd0, 1'b1, 4'd2, 16'h0000, "R9");

    // R10: no change before the clock edge
    src = NL'(1);
    #1;
    chk_out("R10 latch", out_l, m_stat & ~m_mask);
    chk_out("R10 pass",  out_p, m_outp);
    step(64'd1, 1'b0, 4'd8, 16'h0, "R10");

    // R6: status stays after the input drops
    step(64'd0, 1'b0, 4'd8, 16'h0, "R6");
    step(64'd0, 1'b0, 4'd8, 16'h0, "R6");

    // R7: zero write keeps status, one write clears it
    step(64'd0, 1'b1, 4'd8, 16'h0000, "R7");
    step(64'd0, 1'b1, 4'd8, 16'h0001, "R7");

    // R3: mask blocks a high line, then unmask
    step(64'h8, 1'b1, 4'd0, 16'h0008, "R3");
    step(64'h8, 1'b0, 4'd0, 16'h0, "R3");
    step(64'h8, 1'b1, 4'd0, 16'h0000, "R3");

    // R4: polarity inversion of an idle line
    step(64'h8, 1'b1, 4'd4, 16'h0020, "R4");
    step(64'h8, 1'b0, 4'd8, 16'h0, "R4");
    step(64'h28, 1'b0, 4'd8, 16'h0, "R4");
    step(64'h8, 1'b1, 4'd4, 16'h0000, "R4");

    // R8: edge on line 20 with a same-cycle clear of line 20
    step(64'h8, 1'b1, 4'd9, 16'hFFFF, "R8");
    step(64'h8 | (64'd1 << 20), 1'b1, 4'd9, 16'h0010, "R8");
    step(64'h8 | (64'd1 << 20), 1'b0, 4'd9, 16'h0, "R8");

    // R5 and R6 under random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] s;
      logic        w;
      s = {$urandom, $urandom};
      w = ($urandom % 3) == 0;
      step(s, w, 4'($urandom % 16), 16'($urandom), "R5 R6 R2 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule